// File: doc/BRIEF.md
# Speculation-safe ALU with deferred faults

This block wraps a small integer ALU so that work can be done speculatively without raising errors too early. Each operand lane carries a two-bit kind tag and a source-address field next to its data. A lane can hold an ordinary value, a poisoned value, or an empty value. A poisoned value remembers the address of the operation that first went wrong. An empty value means there is nothing to compute.

Arithmetic operations are speculable. They never fault. An error such as a zero divisor or a checked-add overflow turns into a poisoned result tagged with the issuing operation's address. Poison and empty values pass through speculable operations lane by lane. The result tag is recomputed for every result.

Store and branch are non-speculable. If poison reaches one of them, the block raises a one-cycle fault and reports the stored origin address. An empty operand silently cancels the lane it is in. All results are registered, so outputs appear one clock after the operation is presented.

Top module: `spec_fault_alu`

## Requirements
- R1: Kind codes are 00 ordinary, 01 poisoned, 10 empty; an input kind of 11 is treated as empty. After reset every output is zero. Every result appears on the outputs exactly one clock after the operation is presented with `in_valid` high.
- R2: Opcodes are 0 wrapping add, 1 wrapping subtract, 2 checked signed add, 3 unsigned divide, 4 bitwise AND, 5 store, 6 branch. For ordinary operands, a speculable operation yields the arithmetic result per lane with kind 00 and source field zero.
- R3: A checked add whose signed sum overflows yields, in that lane, a poisoned result with data zero and source equal to `op_addr`.
- R4: An unsigned divide by an ordinary zero divisor yields, in that lane, a poisoned result with data zero and source equal to `op_addr`.
- R5: A speculable operation with a poisoned operand yields poison carrying that operand's source, with data zero and no fault. When both operands are poisoned, operand A's source is kept.
- R6: In any lane where either operand is empty, a speculable operation yields kind 10 with data and source zero. This holds even if the other operand is poisoned or the operation would have failed.
- R7: Lanes are independent: an error, poison or empty operand in one lane does not change the result of another lane.
- R8: A store without poison asserts `st_en` for each lane whose two operands are both ordinary. That lane drives A data on `st_data` and B data on `st_addr`. Lanes with an empty operand are not written, and no fault is raised.
- R9: A store with any poisoned operand writes no lane and pulses `fault`. `fault_addr` is the source of the first poisoned operand, scanning lane 0 A, lane 0 B, lane 1 A, and so on upward.
- R10: A branch tests only lane 0 of operand A. If it is ordinary and non-zero, `br_taken` is set. If it is zero or empty, the branch is not taken and there is no fault. If it is poisoned, `fault` pulses with its source and the branch is not taken.
- R11: Non-speculable operations leave `res_valid` low. `fault` rises only one cycle after a store or branch, and clears on the next cycle unless another such fault follows. With `in_valid` low, nothing happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Opcode |
| op_addr | input | AW | Address of the issuing operation |
| a_data | input | LANES*W | Operand A data, lane 0 in the low bits |
| a_kind | input | 2*LANES | Operand A kind tags |
| a_src | input | LANES*AW | Operand A poison sources |
| b_data | input | LANES*W | Operand B data |
| b_kind | input | 2*LANES | Operand B kind tags |
| b_src | input | LANES*AW | Operand B poison sources |
| res_valid | output | 1 | Speculable result present |
| res_data | output | LANES*W | Result data |
| res_kind | output | 2*LANES | Result kind tags |
| res_src | output | LANES*AW | Result poison sources |
| fault | output | 1 | One-cycle fault pulse |
| fault_addr | output | AW | Origin address of the faulting poison |
| st_en | output | LANES | Per-lane store write enable |
| st_data | output | LANES*W | Store data |
| st_addr | output | LANES*W | Store addresses |
| br_taken | output | 1 | Branch taken |

## Verification
The bench builds the block with W=8, LANES=2 and AW=10. The 8-bit width makes signed overflow reachable with small hand-computed literals, in both the positive and negative direction. Two lanes are enough to show that the lanes are independent. They also show that the first-poison scan crosses both the operand boundary and the lane boundary. Ten-bit addresses keep every poison source distinct, so a wrong choice of origin is visible.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    typedef enum logic [1:0] {
        KIND_OK   = 2'b00,
        KIND_BAD  = 2'b01,
        KIND_VOID = 2'b10
    } val_kind_e;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_ADDCHK = 3'd2,
        OP_DIVU   = 3'd3,
        OP_AND    = 3'd4,
        OP_STORE  = 3'd5,
        OP_BRANCH = 3'd6
    } op_e;

    function automatic logic is_spec(input op_e o);
        return (o == OP_ADD) || (o == OP_SUB) || (o == OP_ADDCHK) ||
               (o == OP_DIVU) || (o == OP_AND);
    endfunction

    // Bit 1 set marks an empty value; code 11 folds into empty.
    function automatic logic kind_void(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic kind_bad(input logic [1:0] k);
        return k == KIND_BAD;
    endfunction

endpackage

// File: rtl/sfa_lane.sv
module sfa_lane
    import sfa_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 16
) (
    input  op_e           op,
    input  logic [AW-1:0] op_addr,
    input  logic [W-1:0]  a_data,
    input  logic [1:0]    a_kind,
    input  logic [AW-1:0] a_src,
    input  logic [W-1:0]  b_data,
    input  logic [1:0]    b_kind,
    input  logic [AW-1:0] b_src,
    output logic [W-1:0]  r_data,
    output logic [1:0]    r_kind,
    output logic [AW-1:0] r_src
);

    logic [W-1:0] sum_w;
    logic [W-1:0] diff_w;
    logic [W-1:0] quo_w;
    logic         ovf_w;
    logic         dz_w;
    logic [W-1:0] calc_w;
    logic         err_w;

    always_comb begin
        sum_w  = a_data + b_data;
        diff_w = a_data - b_data;
        dz_w   = (b_data == '0);
        quo_w  = dz_w ? '0 : (a_data / b_data);
        ovf_w  = (a_data[W-1] == b_data[W-1]) && (sum_w[W-1] != a_data[W-1]);
        calc_w = '0;
        err_w  = 1'b0;
        case (op)
            OP_ADD:    calc_w = sum_w;
            OP_SUB:    calc_w = diff_w;
            OP_ADDCHK: begin
                calc_w = sum_w;
                err_w  = ovf_w;
            end
            OP_DIVU:   begin
                calc_w = quo_w;
                err_w  = dz_w;
            end
            OP_AND:    calc_w = a_data & b_data;
            default:   calc_w = '0;
        endcase

        // Empty beats poison; poison beats fresh errors.
        r_data = '0;
        r_kind = KIND_OK;
        r_src  = '0;
        if (kind_void(a_kind) || kind_void(b_kind)) begin
            r_kind = KIND_VOID;
        end else if (kind_bad(a_kind)) begin
            r_kind = KIND_BAD;
            r_src  = a_src;
        end else if (kind_bad(b_kind)) begin
            r_kind = KIND_BAD;
            r_src  = b_src;
        end else if (err_w) begin
            r_kind = KIND_BAD;
            r_src  = op_addr;
        end else begin
            r_data = calc_w;
        end
    end

endmodule

// File: rtl/sfa_first_nar.sv
module sfa_first_nar #(
    parameter int N  = 8,
    parameter int AW = 16
) (
    input  logic [N-1:0]    hit,
    input  logic [N*AW-1:0] src,
    output logic            any,
    output logic [AW-1:0]   addr
);

    always_comb begin
        any  = |hit;
        addr = '0;
        // Walk downward so the lowest index wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) addr = src[i*AW +: AW];
        end
    end

endmodule

// File: rtl/spec_fault_alu.sv
module spec_fault_alu
    import sfa_pkg::*;
#(
    parameter int W     = 32,
    parameter int LANES = 4,
    parameter int AW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [AW-1:0]       op_addr,
    input  logic [LANES*W-1:0]  a_data,
    input  logic [2*LANES-1:0]  a_kind,
    input  logic [LANES*AW-1:0] a_src,
    input  logic [LANES*W-1:0]  b_data,
    input  logic [2*LANES-1:0]  b_kind,
    input  logic [LANES*AW-1:0] b_src,
    output logic                res_valid,
    output logic [LANES*W-1:0]  res_data,
    output logic [2*LANES-1:0]  res_kind,
    output logic [LANES*AW-1:0] res_src,
    output logic                fault,
    output logic [AW-1:0]       fault_addr,
    output logic [LANES-1:0]    st_en,
    output logic [LANES*W-1:0]  st_data,
    output logic [LANES*W-1:0]  st_addr,
    output logic                br_taken
);

    localparam int NCAND = 2 * LANES;

    typedef struct packed {
        logic                res_valid;
        logic [LANES*W-1:0]  res_data;
        logic [2*LANES-1:0]  res_kind;
        logic [LANES*AW-1:0] res_src;
        logic                fault;
        logic [AW-1:0]       fault_addr;
        logic [LANES-1:0]    st_en;
        logic [LANES*W-1:0]  st_data;
        logic [LANES*W-1:0]  st_addr;
        logic                br_taken;
    } out_s;

    op_e op_w;
    assign op_w = op_e'(op);

    logic [W-1:0]      lane_data [LANES];
    logic [1:0]        lane_kind [LANES];
    logic [AW-1:0]     lane_src  [LANES];
    logic [NCAND-1:0]  cand_hit;
    logic [NCAND*AW-1:0] cand_src;
    logic [NCAND-1:0]  pick_hit;
    logic              pick_any;
    logic [AW-1:0]     pick_addr;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            sfa_lane #(.W(W), .AW(AW)) u_lane (
                .op      (op_w),
                .op_addr (op_addr),
                .a_data  (a_data[g*W +: W]),
                .a_kind  (a_kind[2*g +: 2]),
                .a_src   (a_src[g*AW +: AW]),
                .b_data  (b_data[g*W +: W]),
                .b_kind  (b_kind[2*g +: 2]),
                .b_src   (b_src[g*AW +: AW]),
                .r_data  (lane_data[g]),
                .r_kind  (lane_kind[g]),
                .r_src   (lane_src[g])
            );
            // Scan order: lane g operand A, then lane g operand B.
            assign cand_hit[2*g]                  = kind_bad(a_kind[2*g +: 2]);
            assign cand_hit[2*g+1]                = kind_bad(b_kind[2*g +: 2]);
            assign cand_src[(2*g)*AW +: AW]       = a_src[g*AW +: AW];
            assign cand_src[(2*g+1)*AW +: AW]     = b_src[g*AW +: AW];
        end
    endgenerate

    always_comb begin
        pick_hit = '0;
        if (op_w == OP_STORE)       pick_hit = cand_hit;
        else if (op_w == OP_BRANCH) pick_hit[0] = cand_hit[0];
    end

    sfa_first_nar #(.N(NCAND), .AW(AW)) u_pick (
        .hit  (pick_hit),
        .src  (cand_src),
        .any  (pick_any),
        .addr (pick_addr)
    );

    out_s state_d, state_q;

    always_comb begin
        state_d = '0;
        if (in_valid) begin
            if (is_spec(op_w)) begin
                state_d.res_valid = 1'b1;
                for (int i = 0; i < LANES; i++) begin
                    state_d.res_data[i*W +: W]   = lane_data[i];
                    state_d.res_kind[2*i +: 2]   = lane_kind[i];
                    state_d.res_src[i*AW +: AW]  = lane_src[i];
                end
            end else if (op_w == OP_STORE) begin
                if (pick_any) begin
                    state_d.fault      = 1'b1;
                    state_d.fault_addr = pick_addr;
                end else begin
                    for (int i = 0; i < LANES; i++) begin
                        if (!kind_void(a_kind[2*i +: 2]) && !kind_void(b_kind[2*i +: 2])) begin
                            state_d.st_en[i]           = 1'b1;
                            state_d.st_data[i*W +: W]  = a_data[i*W +: W];
                            state_d.st_addr[i*W +: W]  = b_data[i*W +: W];
                        end
                    end
                end
            end else if (op_w == OP_BRANCH) begin
                if (pick_any) begin
                    state_d.fault      = 1'b1;
                    state_d.fault_addr = pick_addr;
                end else if (!kind_void(a_kind[1:0])) begin
                    state_d.br_taken = |a_data[W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_valid  = state_q.res_valid;
    assign res_data   = state_q.res_data;
    assign res_kind   = state_q.res_kind;
    assign res_src    = state_q.res_src;
    assign fault      = state_q.fault;
    assign fault_addr = state_q.fault_addr;
    assign st_en      = state_q.st_en;
    assign st_data    = state_q.st_data;
    assign st_addr    = state_q.st_addr;
    assign br_taken   = state_q.br_taken;

    // A fault only follows a presented store or branch.
    assert_fault_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(in_valid && (op == 3'd5 || op == 3'd6)));

    // A faulting store or branch has no side effect.
    assert_fault_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (st_en == '0 && !br_taken));

    // Speculable results never come with a fault.
    assert_spec_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !fault);

    generate
        for (g = 0; g < LANES; g++) begin : g_chk
            assert_void_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && is_spec(op_w) && (a_kind[2*g+1] || b_kind[2*g+1]))
                |=> (res_kind[2*g +: 2] == 2'b10 && res_src[g*AW +: AW] == '0));
            assert_kind_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |-> (res_kind[2*g +: 2] != 2'b11));
        end
    endgenerate

endmodule

// File: tb/spec_fault_alu_tb_top.sv
`timescale 1ns/1ps
module spec_fault_alu_tb_top;

    localparam int W = 8, LANES = 2, AW = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic [2:0] op;
    logic [AW-1:0] op_addr;
    logic [LANES*W-1:0] a_data, b_data;
    logic [2*LANES-1:0] a_kind, b_kind;
    logic [LANES*AW-1:0] a_src, b_src;
    logic res_valid, fault, br_taken;
    logic [LANES*W-1:0] res_data, st_data, st_addr;
    logic [2*LANES-1:0] res_kind;
    logic [LANES*AW-1:0] res_src;
    logic [AW-1:0] fault_addr;
    logic [LANES-1:0] st_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spec_fault_alu #(.W(W), .LANES(LANES), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .op_addr(op_addr),
        .a_data(a_data), .a_kind(a_kind), .a_src(a_src),
        .b_data(b_data), .b_kind(b_kind), .b_src(b_src),
        .res_valid(res_valid), .res_data(res_data), .res_kind(res_kind), .res_src(res_src),
        .fault(fault), .fault_addr(fault_addr), .st_en(st_en),
        .st_data(st_data), .st_addr(st_addr), .br_taken(br_taken)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  op;
        logic [9:0]  addr;
        logic [15:0] ad;
        logic [3:0]  ak;
        logic [19:0] as_;
        logic [15:0] bd;
        logic [3:0]  bk;
        logic [19:0] bs;
        logic        rv;
        logic [15:0] rd;
        logic [3:0]  rk;
        logic [19:0] rs;
        logic        f;
        logic [9:0]  fa;
        logic [1:0]  st;
        logic        br;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TABLE [NV] = '{
        // R2 wrapping add
        '{8'd2, 3'd0, 10'h005, 16'h10F0, 4'h0, 20'h0, 16'h0120, 4'h0, 20'h0, 1'b1, 16'h1110, 4'h0, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R2 subtract with borrow
        '{8'd2, 3'd1, 10'h005, 16'h0503, 4'h0, 20'h0, 16'h0104, 4'h0, 20'h0, 1'b1, 16'h04FF, 4'h0, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R3 positive overflow in lane 1 only
        '{8'd3, 3'd2, 10'h07A, 16'h7F10, 4'h0, 20'h0, 16'h0120, 4'h0, 20'h0, 1'b1, 16'h0030, 4'h4, 20'h1E800, 1'b0, 10'h0, 2'b00, 1'b0},
        // R3 negative overflow in lane 1, lane 0 -1 + -1 is fine
        '{8'd3, 3'd2, 10'h3FF, 16'h80FF, 4'h0, 20'h0, 16'hFFFF, 4'h0, 20'h0, 1'b1, 16'h00FE, 4'h4, 20'hFFC00, 1'b0, 10'h0, 2'b00, 1'b0},
        // R4 divide by zero in lane 1
        '{8'd4, 3'd3, 10'h123, 16'h0964, 4'h0, 20'h0, 16'h0007, 4'h0, 20'h0, 1'b1, 16'h000E, 4'h4, 20'h48C00, 1'b0, 10'h0, 2'b00, 1'b0},
        // R2 and
        '{8'd2, 3'd4, 10'h006, 16'hF03C, 4'h0, 20'h0, 16'h0FFF, 4'h0, 20'h0, 1'b1, 16'h003C, 4'h0, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R5 poison from A lane 0, from B lane 1
        '{8'd5, 3'd0, 10'h001, 16'h0100, 4'h1, 20'h002AA, 16'h0000, 4'h4, 20'h55400, 1'b1, 16'h0000, 4'h5, 20'h556AA, 1'b0, 10'h0, 2'b00, 1'b0},
        // R5 both poisoned keeps A, beats zero divisor
        '{8'd5, 3'd3, 10'h300, 16'h0600, 4'h1, 20'h00011, 16'h0300, 4'h1, 20'h00022, 1'b1, 16'h0200, 4'h1, 20'h00011, 1'b0, 10'h0, 2'b00, 1'b0},
        // R6 empty beats poison in either order
        '{8'd6, 3'd0, 10'h002, 16'h0000, 4'h6, 20'h33400, 16'h0000, 4'h9, 20'h000AB, 1'b1, 16'h0000, 4'hA, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R6 R7 empty divisor suppresses error; lane 1 still errs
        '{8'd6, 3'd3, 10'h010, 16'h0805, 4'h0, 20'h0, 16'h0000, 4'h2, 20'h0, 1'b1, 16'h0000, 4'h6, 20'h04000, 1'b0, 10'h0, 2'b00, 1'b0},
        // R1 kind 11 acts as empty
        '{8'd1, 3'd0, 10'h004, 16'h0102, 4'h3, 20'h0, 16'h0304, 4'h0, 20'h0, 1'b1, 16'h0400, 4'h2, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R8 full store
        '{8'd8, 3'd5, 10'h050, 16'hAA55, 4'h0, 20'h0, 16'h2120, 4'h0, 20'h0, 1'b0, 16'h0, 4'h0, 20'h0, 1'b0, 10'h0, 2'b11, 1'b0},
        // R8 empty lane 0 not written
        '{8'd8, 3'd5, 10'h051, 16'hAA55, 4'h2, 20'h0, 16'h2120, 4'h0, 20'h0, 1'b0, 16'h0, 4'h0, 20'h0, 1'b0, 10'h0, 2'b10, 1'b0},
        // R9 lane 0 A chosen over lane 1 B
        '{8'd9, 3'd5, 10'h052, 16'h0000, 4'h1, 20'h00111, 16'h0000, 4'h4, 20'hB0C00, 1'b0, 16'h0, 4'h0, 20'h0, 1'b1, 10'h111, 2'b00, 1'b0},
        // R9 empty lane does not hide poison elsewhere
        '{8'd9, 3'd5, 10'h053, 16'h0000, 4'h4, 20'h3C000, 16'h0000, 4'h2, 20'h0, 1'b0, 16'h0, 4'h0, 20'h0, 1'b1, 10'h0F0, 2'b00, 1'b0},
        // R10 taken; poisoned B ignored
        '{8'd10, 3'd6, 10'h060, 16'h0007, 4'h0, 20'h0, 16'h0000, 4'h1, 20'h003AB, 1'b0, 16'h0, 4'h0, 20'h0, 1'b0, 10'h0, 2'b00, 1'b1},
        // R10 zero condition; poisoned lane 1 ignored
        '{8'd10, 3'd6, 10'h061, 16'h0000, 4'h4, 20'h00400, 16'h0000, 4'h0, 20'h0, 1'b0, 16'h0, 4'h0, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R10 empty condition
        '{8'd10, 3'd6, 10'h062, 16'h0005, 4'h2, 20'h0, 16'h0000, 4'h0, 20'h0, 1'b0, 16'h0, 4'h0, 20'h0, 1'b0, 10'h0, 2'b00, 1'b0},
        // R10 poisoned condition faults
        '{8'd10, 3'd6, 10'h063, 16'h0000, 4'h1, 20'h002E5, 16'h0000, 4'h0, 20'h0, 1'b0, 16'h0, 4'h0, 20'h0, 1'b1, 10'h2E5, 2'b00, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid = vld;
        op       = v.op;
        op_addr  = v.addr;
        a_data   = v.ad;
        a_kind   = v.ak;
        a_src    = v.as_;
        b_data   = v.bd;
        b_kind   = v.bk;
        b_src    = v.bs;
    endtask

    task automatic check_vec(input vec_t v);
        string r;
        r = $sformatf("R%0d", v.req);
        chk(r, "res_valid", 32'(res_valid), 32'(v.rv));
        if (v.rv) begin
            chk(r, "res_data", 32'(res_data), 32'(v.rd));
            chk(r, "res_kind", 32'(res_kind), 32'(v.rk));
            chk(r, "res_src", 32'(res_src), 32'(v.rs));
        end
        chk(r, "fault", 32'(fault), 32'(v.f));
        if (v.f) chk(r, "fault_addr", 32'(fault_addr), 32'(v.fa));
        chk(r, "st_en", 32'(st_en), 32'(v.st));
        for (int l = 0; l < LANES; l++) begin
            if (v.st[l]) begin
                chk(r, "st_data", 32'(st_data[l*W +: W]), 32'(v.ad[l*W +: W]));
                chk(r, "st_addr", 32'(st_addr[l*W +: W]), 32'(v.bd[l*W +: W]));
            end
        end
        chk(r, "br_taken", 32'(br_taken), 32'(v.br));
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(TABLE[13], 1'b1);
        repeat (3) @(negedge clk);
        // R1 reset state even with a faulting store presented
        chk("R1", "reset fault", 32'(fault), 0);
        chk("R1", "reset res_valid", 32'(res_valid), 0);
        chk("R1", "reset st_en", 32'(st_en), 0);
        rst_n = 1'b1;
        drive(TABLE[0], 1'b0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(TABLE[i], 1'b1);
            @(negedge clk);
            check_vec(TABLE[i]);
        end

        // R11 fault clears after one cycle when idle follows
        drive(TABLE[17], 1'b0);
        @(negedge clk);
        chk("R11", "fault pulse end", 32'(fault), 0);
        chk("R11", "idle br_taken", 32'(br_taken), 0);

        // R11 in_valid low: faulting store and branch do nothing
        drive(TABLE[13], 1'b0);
        @(negedge clk);
        chk("R11", "idle store fault", 32'(fault), 0);
        chk("R11", "idle st_en", 32'(st_en), 0);
        chk("R11", "idle res_valid", 32'(res_valid), 0);

        // R1 one-cycle latency: full store, then idle clears enables
        drive(TABLE[11], 1'b1);
        @(negedge clk);
        chk("R1", "latency st_en", 32'(st_en), 3);
        drive(TABLE[11], 1'b0);
        @(negedge clk);
        chk("R1", "st_en dropped", 32'(st_en), 0);

        // R9 R11 reset in the same cycle as a faulting store
        drive(TABLE[13], 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "fault under reset", 32'(fault), 0);
        rst_n = 1'b1;
        drive(TABLE[13], 1'b0);
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule